// File: doc/BRIEF.md
# Timer Compare Channel with Converter Start Pulse

This block is one compare channel that sits beside a free-running 16-bit timer. On each timer increment it checks the timer count against a 16-bit compare value that software loads one byte at a time. When the two are equal it does three things on the next clock edge. It sets a sticky interrupt flag. It updates a compare output latch according to the programmed action. If the channel is the selected converter trigger source, it emits a one-cycle start pulse toward an analog-to-digital converter. One edge after that, it emits a one-cycle timer reset request. That reset is dropped if the compare value was rewritten in the meantime so that it no longer equals the matched count.

The compare output is a plain internal signal that other peripherals may consume. Matching is only allowed when the timer runs from the instruction clock (system clock divided by four) or from a synchronized external clock. The other two timer clock sources are reported as unsupported, and while one of them is selected no events are produced. Every pin is a plain control or status line. The block has no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `cmp_trig_channel`

## Requirements
- R1: When `tmr_tick` is 1, the channel is active (`ctrl_wdata` bit 2 last written as 1) and `tmr_count` equals the full 16-bit compare value, `irq_flag` reads 1 after the next clock edge. A tick with any other count sets nothing.
- R2: A cycle with `tmr_tick` at 0 produces no event, even if the count equals the compare value.
- R3: `irq_flag` stays set until a cycle with `flag_clr` at 1. If a clear and a new match fall in the same cycle, the flag stays set.
- R4: `conv_trig` is a one-cycle pulse on the same edge that sets the flag, and it appears only when `trig_sel` was 1 in the matching cycle.
- R5: `tmr_rst` is a one-cycle pulse one edge after the match edge. It follows every match, whatever `trig_sel` is.
- R6: If the compare bytes are written in the cycle between the match edge and the reset edge, and the resulting value differs from the matched count, `tmr_rst` stays 0. A rewrite with the same value keeps the reset.
- R7: `tmr_src` encodes 0 = instruction clock, 1 = synchronized external, 2 = undivided system clock, 3 = asynchronous external. For 2 and 3, `cfg_unsupported` is 1 and no flag, trigger, reset or output change occurs.
- R8: `ctrl_wdata[1:0]` selects the action on a match: 0 drives `cmp_out` high, 1 drives it low, 2 toggles it, 3 leaves it unchanged.
- R9: A control write of all zeros drives `cmp_out` low on the next edge and deactivates matching. A control value with bit 2 at 0 also deactivates matching.
- R10: Compare byte lane 0 holds bits 7:0 and lane 1 holds bits 15:8. The match uses the combined value as it stands, including after a write to one lane only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 3 | Control value: bit 2 active, bits 1:0 action |
| cmp_byte_wr | input | 2 | Per-lane compare write strobes |
| cmp_byte_data | input | 8 | Compare byte data |
| trig_sel | input | 1 | Channel chosen as converter trigger source |
| tmr_count | input | 16 | Timer count value |
| tmr_tick | input | 1 | Timer incremented this cycle |
| tmr_src | input | 2 | Timer clock source code |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cmp_out | output | 1 | Compare output latch |
| irq_flag | output | 1 | Sticky interrupt flag |
| conv_trig | output | 1 | Converter start pulse |
| tmr_rst | output | 1 | Timer reset request pulse |
| cfg_unsupported | output | 1 | Timer clock source not valid for compare |

## Verification
Two collisions can land in one cycle. The first is a software flag clear against a fresh match. The bench drives `flag_clr` and a matching tick together and expects the flag to read set afterwards. The second is a compare-byte write against the pending timer reset. The bench writes a lane in the cycle after the match edge, once with a differing value and once with the same value, and expects the reset to be dropped in the first case and issued in the second.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    ACT_SET  = 2'd0,
    ACT_CLR  = 2'd1,
    ACT_TGL  = 2'd2,
    ACT_NONE = 2'd3
  } cmp_act_e;

  typedef enum logic [1:0] {
    SRC_INSTR = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_SYS   = 2'd2,
    SRC_ASYNC = 2'd3
  } clk_src_e;

  function automatic logic src_ok(input clk_src_e s);
    return (s == SRC_INSTR) || (s == SRC_SYNC);
  endfunction
endpackage

// File: rtl/cmp_reg_bytes.sv
module cmp_reg_bytes #(
  parameter int TW = 16,
  parameter int BW = 8,
  localparam int NB = TW / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] byte_wr,
  input  logic [BW-1:0] byte_data,
  output logic [TW-1:0] cmp_q,
  output logic [TW-1:0] cmp_nxt
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign cmp_nxt[i*BW +: BW] = byte_wr[i] ? byte_data : cmp_q[i*BW +: BW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[i*BW +: BW] <= '0;
      else        cmp_q[i*BW +: BW] <= cmp_nxt[i*BW +: BW];
    end
  end
endmodule

// File: rtl/cmp_match.sv
module cmp_match
  import cmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          tick,
  input  logic          active,
  input  clk_src_e      src,
  input  logic [TW-1:0] count,
  input  logic [TW-1:0] cmp_q,
  output logic          hit,
  output logic          unsupported
);
  logic equal;
  assign equal       = (count == cmp_q);
  assign unsupported = !src_ok(src);
  assign hit         = tick && active && !unsupported && equal;
endmodule

// File: rtl/cmp_event_seq.sv
module cmp_event_seq #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          trig_sel,
  input  logic          flag_clr,
  input  logic [TW-1:0] count,
  input  logic [TW-1:0] cmp_nxt,
  output logic          irq_flag,
  output logic          conv_trig,
  output logic          tmr_rst
);
  logic          pend;
  logic [TW-1:0] pend_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag  <= 1'b0;
      conv_trig <= 1'b0;
      tmr_rst   <= 1'b0;
      pend      <= 1'b0;
      pend_cnt  <= '0;
    end else begin
      irq_flag  <= hit || (irq_flag && !flag_clr);
      conv_trig <= hit && trig_sel;
      pend      <= hit;
      if (hit) pend_cnt <= count;
      tmr_rst   <= pend && (pend_cnt == cmp_nxt);
    end
  end
endmodule

// File: rtl/cmp_trig_channel.sv
module cmp_trig_channel
  import cmp_pkg::*;
#(
  parameter int TW = 16,
  parameter int BW = 8,
  localparam int NB = TW / BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic [2:0]    ctrl_wdata,
  input  logic [NB-1:0] cmp_byte_wr,
  input  logic [BW-1:0] cmp_byte_data,
  input  logic          trig_sel,
  input  logic [TW-1:0] tmr_count,
  input  logic          tmr_tick,
  input  logic [1:0]    tmr_src,
  input  logic          flag_clr,
  output logic          cmp_out,
  output logic          irq_flag,
  output logic          conv_trig,
  output logic          tmr_rst,
  output logic          cfg_unsupported
);
  logic [2:0]    ctrl_q;
  logic [TW-1:0] cmp_q, cmp_nxt;
  logic          hit;
  cmp_act_e      act;

  assign act = cmp_act_e'(ctrl_q[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_wdata;
  end

  cmp_reg_bytes #(.TW(TW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_wr(cmp_byte_wr), .byte_data(cmp_byte_data),
    .cmp_q(cmp_q), .cmp_nxt(cmp_nxt)
  );

  cmp_match #(.TW(TW)) u_match (
    .tick(tmr_tick), .active(ctrl_q[2]), .src(clk_src_e'(tmr_src)),
    .count(tmr_count), .cmp_q(cmp_q), .hit(hit), .unsupported(cfg_unsupported)
  );

  cmp_event_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .hit(hit), .trig_sel(trig_sel), .flag_clr(flag_clr),
    .count(tmr_count), .cmp_nxt(cmp_nxt),
    .irq_flag(irq_flag), .conv_trig(conv_trig), .tmr_rst(tmr_rst)
  );

  // Output latch: an all-zero control write wins over a same-cycle match.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_out <= 1'b0;
    else if (ctrl_wr && ctrl_wdata == 3'b000) cmp_out <= 1'b0;
    else if (hit) begin
      unique case (act)
        ACT_SET:  cmp_out <= 1'b1;
        ACT_CLR:  cmp_out <= 1'b0;
        ACT_TGL:  cmp_out <= !cmp_out;
        ACT_NONE: cmp_out <= cmp_out;
      endcase
    end
  end
endmodule

// File: rtl/cmp_trig_channel_chk.sv
module cmp_trig_channel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctrl_wr,
  input logic [2:0] ctrl_wdata,
  input logic       trig_sel,
  input logic       tmr_tick,
  input logic       flag_clr,
  input logic       cmp_out,
  input logic       irq_flag,
  input logic       conv_trig,
  input logic       tmr_rst,
  input logic       cfg_unsupported
);
  // R2
  flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(tmr_tick));
  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !flag_clr |=> irq_flag);
  // R4
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |=> !conv_trig);
  // R4
  trig_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> ($past(trig_sel) && irq_flag));
  // R5
  rst_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |-> $past(irq_flag));
  // R7
  no_trig_unsupported_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_trig |-> !$past(cfg_unsupported));
  // R9
  zero_ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata == 3'b000) |=> !cmp_out);
endmodule

bind cmp_trig_channel cmp_trig_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .trig_sel(trig_sel), .tmr_tick(tmr_tick), .flag_clr(flag_clr),
  .cmp_out(cmp_out), .irq_flag(irq_flag), .conv_trig(conv_trig),
  .tmr_rst(tmr_rst), .cfg_unsupported(cfg_unsupported)
);

// File: tb/cmp_trig_channel_bench.sv
module cmp_trig_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_wr = 1'b0;
  logic [2:0]  ctrl_wdata = '0;
  logic [1:0]  cmp_byte_wr = '0;
  logic [7:0]  cmp_byte_data = '0;
  logic        trig_sel = 1'b0;
  logic [15:0] tmr_count = '0;
  logic        tmr_tick = 1'b0;
  logic [1:0]  tmr_src = '0;
  logic        flag_clr = 1'b0;
  logic        cmp_out, irq_flag, conv_trig, tmr_rst, cfg_unsupported;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic exp_out = 1'b0;

  always #4 clk = !clk;

  cmp_trig_channel u_cmp_trig_channel (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .cmp_byte_wr(cmp_byte_wr), .cmp_byte_data(cmp_byte_data), .trig_sel(trig_sel),
    .tmr_count(tmr_count), .tmr_tick(tmr_tick), .tmr_src(tmr_src), .flag_clr(flag_clr),
    .cmp_out(cmp_out), .irq_flag(irq_flag), .conv_trig(conv_trig),
    .tmr_rst(tmr_rst), .cfg_unsupported(cfg_unsupported)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_ctrl(input logic [2:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_cmp(input logic [15:0] v);
    cmp_byte_wr = 2'b01; cmp_byte_data = v[7:0];
    @(negedge clk);
    cmp_byte_wr = 2'b10; cmp_byte_data = v[15:8];
    @(negedge clk);
    cmp_byte_wr = 2'b00;
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic tick_at(input logic [15:0] c);
    tmr_count = c; tmr_tick = 1'b1;
    @(negedge clk);
    tmr_tick = 1'b0;
  endtask

  function automatic logic apply_act(input logic [1:0] a, input logic o);
    case (a)
      2'd0: return 1'b1;
      2'd1: return 1'b0;
      2'd2: return !o;
      default: return o;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset flag", irq_flag, 1'b0);
    chk("R9 reset out", cmp_out, 1'b0);
    chk("R4 reset trig", conv_trig, 1'b0);
    chk("R5 reset rst", tmr_rst, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: control value x trigger select x clock source
    for (int mi = 0; mi < 6; mi++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int src = 0; src < 4; src++) begin
          logic [2:0]  cv;
          logic [15:0] v;
          logic        fire;
          cv = (mi == 0) ? 3'b000 : (mi == 5) ? 3'b010 : {1'b1, 2'(mi - 1)};
          v  = 16'h1234 + 16'(mi) * 16'h0411 + 16'(sel) * 16'h0101 + 16'(src) * 16'h2003;
          wr_ctrl(cv);
          if (cv == 3'b000) exp_out = 1'b0;
          chk("R9 out after ctrl", cmp_out, exp_out);
          wr_cmp(v);
          clr_flag();
          trig_sel = sel[0]; tmr_src = src[1:0];
          tick_at(v ^ 16'h0100);
          chk("R1 mismatch no flag", irq_flag, 1'b0);
          chk("R7 unsupported", cfg_unsupported, src >= 2);
          @(negedge clk);
          chk("R5 mismatch no rst", tmr_rst, 1'b0);
          tick_at(v);
          fire = cv[2] && (src < 2);
          if (fire) exp_out = apply_act(cv[1:0], exp_out);
          chk("R1 R7 R9 match flag", irq_flag, fire);
          chk("R4 trig", conv_trig, fire && sel[0]);
          chk("R8 out", cmp_out, exp_out);
          chk("R5 no early rst", tmr_rst, 1'b0);
          @(negedge clk);
          chk("R5 rst", tmr_rst, fire);
          chk("R4 trig single", conv_trig, 1'b0);
          @(negedge clk);
          chk("R5 rst single", tmr_rst, 1'b0);
        end
      end
    end

    // R2: held count without tick
    tmr_src = 2'd0; trig_sel = 1'b1;
    wr_ctrl(3'b100);
    wr_cmp(16'h5A5A);
    clr_flag();
    tmr_count = 16'h5A5A; tmr_tick = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 no tick", irq_flag, 1'b0);
    chk("R2 no tick trig", conv_trig, 1'b0);
    tick_at(16'h5A5A);
    chk("R2 tick fires", irq_flag, 1'b1);
    chk("R8 set", cmp_out, 1'b1);
    @(negedge clk);

    // R3: clear and match collide
    flag_clr = 1'b1;
    tick_at(16'h5A5A);
    flag_clr = 1'b0;
    chk("R3 clear+match", irq_flag, 1'b1);
    @(negedge clk);
    chk("R3 held", irq_flag, 1'b1);
    clr_flag();
    chk("R3 cleared", irq_flag, 1'b0);

    // R6: differing rewrite cancels reset
    tick_at(16'h5A5A);
    cmp_byte_wr = 2'b10; cmp_byte_data = 8'h77;
    @(negedge clk);
    cmp_byte_wr = 2'b00;
    chk("R6 cancelled", tmr_rst, 1'b0);
    @(negedge clk);
    chk("R6 still none", tmr_rst, 1'b0);
    // R6: same-value rewrite keeps reset (compare is now 0x775A)
    clr_flag();
    tick_at(16'h775A);
    cmp_byte_wr = 2'b01; cmp_byte_data = 8'h5A;
    @(negedge clk);
    cmp_byte_wr = 2'b00;
    chk("R6 same value keeps", tmr_rst, 1'b1);

    // R10: single-lane write
    wr_cmp(16'hABCD);
    clr_flag();
    cmp_byte_wr = 2'b01; cmp_byte_data = 8'h11;
    @(negedge clk);
    cmp_byte_wr = 2'b00;
    tick_at(16'hABCD);
    chk("R10 old value gone", irq_flag, 1'b0);
    tick_at(16'hAB11);
    chk("R10 combined value", irq_flag, 1'b1);
    @(negedge clk);

    // R9: zero write drops output and stops matching
    chk("R9 out high before", cmp_out, 1'b1);
    wr_ctrl(3'b000);
    chk("R9 forced low", cmp_out, 1'b0);
    clr_flag();
    tick_at(16'hAB11);
    chk("R9 inactive", irq_flag, 1'b0);
    @(negedge clk);
    chk("R9 no rst", tmr_rst, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule